// File: doc/BRIEF.md
# Debug Trigger Match Sequencer

This block is the state machine at the heart of an on-chip debug trigger. Three comparator channels (0, 1, 2) deliver match pulses. The sequencer moves through three working states and then a terminal Final state. Reaching Final is the trigger condition. In each working state, a 4-bit control code decides which channel's match leads where. A match on a channel that the active code does not name changes nothing.

Software loads the three control codes through a small write port, and only while the unit is disarmed. Raising `arm_i` starts the sequence from State1. Once in Final, the sequencer stays there until `arm_i` drops, which sends it back to State1. A single-cycle pulse marks the entry into Final, so a capture or halt engine downstream can act on it.

Each code names, for every channel, one of four actions: none, slot A, slot B or Final. The slots resolve to a different state in each working state:

| Current state | Slot A leads to | Slot B leads to |
|---|---|---|
| State1 | State2 | State3 |
| State2 | State3 | State1 |
| State3 | State1 | State2 |

Top module: `dbg_match_seq`

## Requirements
- R1: After reset, `state_o` is State1 and `final_pulse_o` is low. All three control codes reset to 0000, so no match moves the sequencer until a code is written.
- R2: `state_o` uses the encoding 0 = State1, 1 = State2, 2 = State3, 3 = Final. A transition caused by the inputs sampled at one rising edge is visible on `state_o` right after that edge.
- R3: In State1, the code selects actions per channel as follows:
  - 0001: ch0 to slot A.
  - 0010: ch1 to slot A.
  - 0011: ch2 to slot A.
  - 0100: ch0 to slot B.
  - 0101: ch1 to slot B.
  - 0110: ch0 to slot A, and ch1 to slot B.
  - 0111: ch0 to slot A, and ch2 to slot B.
  - 1000: ch0 or ch1 to slot A.
  - 1001: ch0 to Final, and ch1 to slot B.
  - 1101: ch0 or ch2 to Final, and ch1 to slot A.
  - 1111: every channel to Final.
  - 0000, 1010, 1011, 1100 and 1110 name no channel.
- R4: State2 and State3 use the same code table as State1, each with its own code and its own slot targets as given in the table above.
- R5: A match on a channel that the active code does not name, or a cycle with no match, leaves the state unchanged.
- R6: When several matches arrive in the same cycle, a match whose action is Final wins. Otherwise the lowest-numbered matching channel decides. With code 1101, a joint match on ch0 and ch1 enters Final.
- R7: A channel's match counts only when its bit in `cmp_en_i` is 1.
- R8: A write with `wr_en_i` high and `arm_i` low loads `wr_data_i` into a code, effective from the next cycle. `wr_sel_i` picks the code: 0 for the State1 code, 1 for State2, 2 for State3. A value of 3 writes nothing. Writes made while `arm_i` is high are ignored.
- R9: With `arm_i` low, the sequencer returns to State1 at the next edge, and no match moves it.
- R10: While armed, Final is held regardless of matches.
- R11: `final_pulse_o` is high for exactly the first cycle in which `state_o` shows Final, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Sequencer armed; low forces State1 and opens the write port |
| cmp_en_i | input | 3 | Per-channel comparator enable |
| match_i | input | 3 | Per-channel raw match pulse |
| wr_en_i | input | 1 | Control code write strobe |
| wr_sel_i | input | 2 | Code select: 0 State1, 1 State2, 2 State3, 3 none |
| wr_data_i | input | 4 | Code value to write |
| state_o | output | 2 | Current state (0 State1, 1 State2, 2 State3, 3 Final) |
| final_pulse_o | output | 1 | One-cycle pulse on entry to Final |

## Verification
The two functions that share a cycle are the Final-first rule and the lowest-channel rule. They collide whenever two or three channels match together under a code that gives them different actions. The bench provokes this exhaustively: for every one of the 16 codes in each of the three working states, it applies every non-empty combination of simultaneous matches. A reference model in the bench, written from the code table and the priority rule, predicts the next state and pulse, and the scoreboard compares that prediction against the ports after the edge. A deliberate case with code 1101 and matches on ch0 and ch1 pins the case where Final must beat a lower-numbered slot move.

// File: rtl/dbgseq_pkg.sv
package dbgseq_pkg;

    localparam int NUM_CH  = 3;
    localparam int CODE_W  = 4;
    localparam int NUM_FLD = 3;
    localparam int SEL_W   = $clog2(NUM_FLD + 1);

    typedef enum logic [1:0] {
        ST_ONE   = 2'd0,
        ST_TWO   = 2'd1,
        ST_THREE = 2'd2,
        ST_FIN   = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_A    = 2'd1,
        ACT_B    = 2'd2,
        ACT_FIN  = 2'd3
    } act_e;

    typedef act_e [NUM_CH-1:0] act_vec_t;

    // Per-channel action for one control code; shared by all working states.
    function automatic act_vec_t code_lookup(input logic [CODE_W-1:0] code);
        act_vec_t a;
        for (int c = 0; c < NUM_CH; c++) a[c] = ACT_NONE;
        case (code)
            4'b0001: a[0] = ACT_A;
            4'b0010: a[1] = ACT_A;
            4'b0011: a[2] = ACT_A;
            4'b0100: a[0] = ACT_B;
            4'b0101: a[1] = ACT_B;
            4'b0110: begin a[0] = ACT_A;   a[1] = ACT_B; end
            4'b0111: begin a[0] = ACT_A;   a[2] = ACT_B; end
            4'b1000: begin a[0] = ACT_A;   a[1] = ACT_A; end
            4'b1001: begin a[0] = ACT_FIN; a[1] = ACT_B; end
            4'b1101: begin a[0] = ACT_FIN; a[2] = ACT_FIN; a[1] = ACT_A; end
            4'b1111: for (int c = 0; c < NUM_CH; c++) a[c] = ACT_FIN;
            default: ;
        endcase
        return a;
    endfunction

    // Resolves an action into a concrete state for the current working state.
    function automatic seq_state_e slot_target(input seq_state_e cur, input act_e act);
        seq_state_e t;
        t = cur;
        if (act == ACT_FIN) begin
            t = ST_FIN;
        end else if (act != ACT_NONE) begin
            case (cur)
                ST_ONE:   t = (act == ACT_A) ? ST_TWO   : ST_THREE;
                ST_TWO:   t = (act == ACT_A) ? ST_THREE : ST_ONE;
                ST_THREE: t = (act == ACT_A) ? ST_ONE   : ST_TWO;
                default:  t = ST_FIN;
            endcase
        end
        return t;
    endfunction

endpackage

// File: rtl/seq_ctl_regs.sv
module seq_ctl_regs
    import dbgseq_pkg::*;
#(
    parameter logic [CODE_W-1:0] RST_CODE = '0
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             arm,
    input  logic                             wr_en,
    input  logic [SEL_W-1:0]                 wr_sel,
    input  logic [CODE_W-1:0]                wr_data,
    output logic [NUM_FLD-1:0][CODE_W-1:0]   fld_o
);

    typedef struct packed {
        logic [NUM_FLD-1:0][CODE_W-1:0] fld;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic wr_ok;

    always_comb begin
        ctl_d = ctl_q;
        wr_ok = wr_en && !arm;
        for (int f = 0; f < NUM_FLD; f++) begin
            if (wr_ok && (wr_sel == SEL_W'(f))) ctl_d.fld[f] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q.fld <= {NUM_FLD{RST_CODE}};
        else        ctl_q     <= ctl_d;
    end

    assign fld_o = ctl_q.fld;

    // R8: codes are frozen while armed
    p_wr_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> $stable(fld_o));

    // R8: an out-of-range select loads nothing
    p_sel_void_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel >= SEL_W'(NUM_FLD)) |=> $stable(fld_o));

endmodule

// File: rtl/seq_route.sv
module seq_route
    import dbgseq_pkg::*;
(
    input  seq_state_e          cur_i,
    input  logic [CODE_W-1:0]   code_i,
    input  logic [NUM_CH-1:0]   hit_i,
    output seq_state_e          nxt_o,
    output logic                move_o
);

    act_vec_t            acts;
    logic [NUM_CH-1:0]   fin_hit;
    logic [NUM_CH-1:0]   mv_hit;
    seq_state_e          tgt [NUM_CH];

    assign acts = code_lookup(code_i);

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            assign fin_hit[c] = hit_i[c] && (acts[c] == ACT_FIN);
            assign mv_hit[c]  = hit_i[c] && (acts[c] != ACT_NONE);
            assign tgt[c]     = slot_target(cur_i, acts[c]);
        end
    endgenerate

    // Final first, then the lowest-numbered named channel.
    always_comb begin
        nxt_o  = cur_i;
        move_o = 1'b0;
        if (|fin_hit) begin
            nxt_o  = ST_FIN;
            move_o = 1'b1;
        end else begin
            for (int c = NUM_CH - 1; c >= 0; c--) begin
                if (mv_hit[c]) begin
                    nxt_o  = tgt[c];
                    move_o = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/dbg_match_seq.sv
module dbg_match_seq
    import dbgseq_pkg::*;
#(
    parameter logic [CODE_W-1:0] RST_CODE = '0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        arm_i,
    input  logic [2:0]  cmp_en_i,
    input  logic [2:0]  match_i,
    input  logic        wr_en_i,
    input  logic [1:0]  wr_sel_i,
    input  logic [3:0]  wr_data_i,
    output logic [1:0]  state_o,
    output logic        final_pulse_o
);

    typedef struct packed {
        seq_state_e st;
        logic       pulse;
    } seq_t;

    seq_t                            seq_d, seq_q;
    logic [NUM_FLD-1:0][CODE_W-1:0]  fld;
    logic [CODE_W-1:0]               cur_code;
    logic [NUM_CH-1:0]               hits;
    seq_state_e                      route_nxt;
    logic                            route_move;

    assign hits = match_i & cmp_en_i;

    seq_ctl_regs #(.RST_CODE(RST_CODE)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm_i),
        .wr_en   (wr_en_i),
        .wr_sel  (wr_sel_i),
        .wr_data (wr_data_i),
        .fld_o   (fld)
    );

    always_comb begin
        case (seq_q.st)
            ST_ONE:   cur_code = fld[0];
            ST_TWO:   cur_code = fld[1];
            ST_THREE: cur_code = fld[2];
            default:  cur_code = '0;
        endcase
    end

    seq_route i_route (
        .cur_i  (seq_q.st),
        .code_i (cur_code),
        .hit_i  (hits),
        .nxt_o  (route_nxt),
        .move_o (route_move)
    );

    always_comb begin
        seq_d       = seq_q;
        seq_d.pulse = 1'b0;
        if (!arm_i) begin
            seq_d.st = ST_ONE;
        end else if (seq_q.st != ST_FIN && route_move) begin
            seq_d.st    = route_nxt;
            seq_d.pulse = (route_nxt == ST_FIN);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: ST_ONE, pulse: 1'b0};
        else        seq_q <= seq_d;
    end

    assign state_o       = seq_q.st;
    assign final_pulse_o = seq_q.pulse;

    p_disarm_home_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_i |=> (state_o == ST_ONE));

    p_fin_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_i && state_o == ST_FIN) |=> (state_o == ST_FIN));

    p_pulse_entry_r11: assert property (@(posedge clk) disable iff (!rst_n)
        final_pulse_o |-> (state_o == ST_FIN && $past(state_o) != ST_FIN));

    p_pulse_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        final_pulse_o |=> !final_pulse_o);

    p_quiet_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_i && (match_i & cmp_en_i) == 3'b000) |=> $stable(state_o));

endmodule

// File: tb/test_dbg_match_seq.sv
`timescale 1ns/1ps
module test_dbg_match_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       arm = 1'b0;
    logic [2:0] cmp_en = 3'b000;
    logic [2:0] match = 3'b000;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [3:0] wr_data = 4'd0;
    logic [1:0] state_o;
    logic       final_pulse_o;

    always #2 clk = ~clk;

    dbg_match_seq i_dbg_match_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .arm_i         (arm),
        .cmp_en_i      (cmp_en),
        .match_i       (match),
        .wr_en_i       (wr_en),
        .wr_sel_i      (wr_sel),
        .wr_data_i     (wr_data),
        .state_o       (state_o),
        .final_pulse_o (final_pulse_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [2:0] exp_q[$];
    string      tag_q[$];
    logic [1:0] m_state = 2'd0;
    logic [3:0] m_code [3];

    // Action per channel from the R3 table: 0 none, 1 slot A, 2 slot B, 3 Final
    function automatic int ref_act(input logic [3:0] code, input int ch);
        int a[3];
        a = '{0, 0, 0};
        case (code)
            4'h1: a[0] = 1;
            4'h2: a[1] = 1;
            4'h3: a[2] = 1;
            4'h4: a[0] = 2;
            4'h5: a[1] = 2;
            4'h6: a = '{1, 2, 0};
            4'h7: a = '{1, 0, 2};
            4'h8: a = '{1, 1, 0};
            4'h9: a = '{3, 2, 0};
            4'hD: a = '{3, 1, 3};
            4'hF: a = '{3, 3, 3};
            default: ;
        endcase
        return a[ch];
    endfunction

    // Slot targets per state (R3, R4)
    function automatic logic [1:0] ref_slot(input logic [1:0] cur, input int act);
        if (act == 3) return 2'd3;
        case (cur)
            2'd0:    return (act == 1) ? 2'd1 : 2'd2;
            2'd1:    return (act == 1) ? 2'd2 : 2'd0;
            2'd2:    return (act == 1) ? 2'd0 : 2'd1;
            default: return 2'd3;
        endcase
    endfunction

    task automatic drive(input logic a, input logic [2:0] en, input logic [2:0] m,
                         input logic we, input logic [1:0] sel, input logic [3:0] d,
                         input string tag);
        logic [1:0] nxt;
        logic [2:0] h;
        logic       pls;
        bit         found;
        @(negedge clk);
        arm = a; cmp_en = en; match = m; wr_en = we; wr_sel = sel; wr_data = d;
        h = m & en;
        nxt = m_state;
        pls = 1'b0;
        found = 0;
        if (!a) begin
            nxt = 2'd0;
        end else if (m_state != 2'd3) begin
            for (int c = 0; c < 3; c++)
                if (h[c] && ref_act(m_code[m_state], c) == 3) found = 1;
            if (found) begin
                nxt = 2'd3;
            end else begin
                for (int c = 2; c >= 0; c--)
                    if (h[c] && ref_act(m_code[m_state], c) != 0)
                        nxt = ref_slot(m_state, ref_act(m_code[m_state], c));
            end
            pls = (nxt == 2'd3);
        end
        if (we && !a && sel < 2'd3) m_code[sel] = d;
        m_state = nxt;
        exp_q.push_back({nxt, pls});
        tag_q.push_back(tag);
    endtask

    // Monitor: compares one predicted item after each edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [2:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if ({state_o, final_pulse_o} !== e) begin
                n_bad++;
                $display("FAIL %s: state/pulse got %0d/%0d expected %0d/%0d",
                         t, state_o, final_pulse_o, e[2:1], e[0]);
            end
        end
    end

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL R2 watchdog: run still busy, got hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) m_code[i] = 4'd0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        n_cmp++;
        if (state_o !== 2'd0 || final_pulse_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: state/pulse got %0d/%0d expected 0/0", state_o, final_pulse_o);
        end
        // R1: codes reset to 0000, so nothing moves
        drive(1, 3'b111, 3'b111, 0, 0, 0, "R1");
        drive(1, 3'b111, 3'b101, 0, 0, 0, "R1");

        // R6: code 1101 with ch0+ch1 enters Final
        drive(0, 3'b111, 0, 1, 0, 4'hD, "R8");
        drive(1, 3'b111, 3'b011, 0, 0, 0, "R6");
        drive(1, 3'b111, 3'b111, 0, 0, 0, "R10");
        drive(0, 3'b111, 0, 0, 0, 0, "R9");

        // R3, R5, R6: every State1 code with every match combination
        for (int code = 0; code < 16; code++) begin
            for (int h = 1; h < 8; h++) begin
                drive(0, 3'b111, 0, 1, 0, 4'(code), "R8");
                drive(1, 3'b111, 3'(h), 0, 0, 0, "R3");
                drive(1, 3'b111, 0, 0, 0, 0, "R5");
            end
        end

        // R4: State2 table, entered through code 0001 on ch0
        drive(0, 3'b111, 0, 1, 0, 4'h1, "R8");
        for (int code = 0; code < 16; code++) begin
            for (int h = 1; h < 8; h++) begin
                drive(0, 3'b111, 0, 1, 1, 4'(code), "R8");
                drive(1, 3'b111, 3'b001, 0, 0, 0, "R3");
                drive(1, 3'b111, 3'(h), 0, 0, 0, "R4");
                drive(1, 3'b111, 0, 0, 0, 0, "R5");
            end
        end

        // R4: State3 table, entered through code 0100 on ch0
        drive(0, 3'b111, 0, 1, 0, 4'h4, "R8");
        for (int code = 0; code < 16; code++) begin
            for (int h = 1; h < 8; h++) begin
                drive(0, 3'b111, 0, 1, 2, 4'(code), "R8");
                drive(1, 3'b111, 3'b001, 0, 0, 0, "R3");
                drive(1, 3'b111, 3'(h), 0, 0, 0, "R4");
                drive(1, 3'b111, 0, 0, 0, 0, "R5");
            end
        end

        // R7: disabled channels are ignored; R10/R11 hold and single pulse
        drive(0, 3'b111, 0, 1, 0, 4'hF, "R8");
        drive(1, 3'b000, 3'b111, 0, 0, 0, "R7");
        drive(1, 3'b100, 3'b011, 0, 0, 0, "R7");
        drive(1, 3'b100, 3'b100, 0, 0, 0, "R7");
        drive(1, 3'b111, 3'b111, 0, 0, 0, "R10");
        drive(1, 3'b111, 3'b111, 0, 0, 0, "R11");
        drive(1, 3'b111, 0, 0, 0, 0, "R10");
        drive(0, 3'b111, 3'b111, 0, 0, 0, "R9");

        // R8: armed write ignored, select 3 writes nothing
        drive(0, 3'b111, 0, 1, 0, 4'h0, "R8");
        drive(1, 3'b111, 0, 1, 0, 4'hF, "R8");
        drive(1, 3'b111, 3'b111, 0, 0, 0, "R8");
        drive(0, 3'b111, 0, 1, 3, 4'hF, "R8");
        drive(1, 3'b111, 3'b111, 0, 0, 0, "R8");

        // R9: disarm from State2 while matches continue
        drive(0, 3'b111, 0, 1, 0, 4'h1, "R8");
        drive(1, 3'b111, 3'b001, 0, 0, 0, "R2");
        drive(0, 3'b111, 3'b111, 0, 0, 0, "R9");
        drive(0, 3'b111, 3'b111, 0, 0, 0, "R9");

        @(posedge clk);
        #2;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule